// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit byte virtual address into a physical address by walking a two-level page table in memory. A request carries the virtual address, a store flag and the byte address of the root table. The walker reads one entry from the root table and then one entry from the second-level table that the root entry selects. It returns the physical address together with the final table entry, or it returns a fault that names the level where the walk stopped.

Pages are 4 KB. The top ten address bits select the root entry, the next ten select the second-level entry, and the low twelve bits pass through unchanged as the page offset. Each entry is one 32-bit word. Bit 0 marks the entry as present, bit 1 marks the page as modified, bits 31:12 hold a frame number, and bits 11:2 are reserved. A root entry's frame number is the base of a second-level table. A store that reaches a leaf entry whose modified bit is clear writes that entry back with the bit set before the walker responds.

The memory port is word addressed. It has a request handshake (valid/ready) and a one-cycle response strobe that comes for every accepted request, read or write. Only one walk is in flight at a time.

Top module: `pgw_walker`

## Requirements
- R1: While reset is asserted, req_ready is 1 and both resp_valid and mem_req_valid are 0.
- R2: The first memory access of every walk is a read at word address {root_base[31:12], vaddr[31:22]}. This equals the byte address root_base + 4*vaddr[31:22]. Bits 11:0 of root_base are ignored.
- R3: When the root entry has bit 0 set, the second access is a read at word address {root_entry[31:12], vaddr[21:12]}.
- R4: A successful walk responds with resp_fault=0, resp_paddr = {leaf_entry[31:12], vaddr[11:0]}, resp_vpn = vaddr[31:12] and resp_pte = the leaf entry, with bit 1 set if it was written back.
- R5: A root entry with bit 0 clear ends the walk after one read. The response has resp_fault=1, resp_fault_leaf=0, resp_paddr=0, resp_pte = root entry and resp_vpn = vaddr[31:12].
- R6: A leaf entry with bit 0 clear ends the walk after two reads. The response has resp_fault=1, resp_fault_leaf=1, resp_paddr=0 and resp_pte = leaf entry.
- R7: A store (req_store=1) whose present leaf entry has bit 1 clear issues, before the response, exactly one write to the leaf entry's word address. The write data is the leaf entry with bit 1 set.
- R8: A load, or a store whose leaf entry already has bit 1 set, makes no memory write. Such a walk makes exactly two reads.
- R9: req_ready stays 0 from the accepting edge until the response handshake completes, and is 1 again on the next cycle. While resp_valid is 1 and resp_ready is 0, every response output holds its value.
- R10: Entry bits 11:2 do not affect any address or fault decision. They are returned unchanged in resp_pte.
- R11: While mem_req_valid is 1 and mem_req_ready is 0, mem_addr, mem_we and mem_wdata hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual byte address |
| req_store | input | 1 | Request is a store |
| req_root_base | input | 32 | Byte address of the root table (low 12 bits ignored) |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Consumer takes the response |
| resp_fault | output | 1 | Walk hit a non-present entry |
| resp_fault_leaf | output | 1 | Fault was at the second level (0 = root) |
| resp_paddr | output | 32 | Physical address, zero on a fault |
| resp_pte | output | 32 | Last entry read (leaf entry as written back) |
| resp_vpn | output | 20 | Virtual page number of the request |
| mem_req_valid | output | 1 | Memory access request |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 30 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | One-cycle completion strobe for an accepted access |
| mem_rdata | input | 32 | Read data, valid with mem_rsp_valid |

## Verification
The bench targets faults at each level separately. A walker that mixed up the levels would report the wrong level, or would issue a second read after a root fault. It also runs stores against leaf entries whose modified bit is already set and against ones where it is clear. A walker that tested the bit the wrong way would write back pages that are already marked, or would skip the write-back. The extreme addresses 0 and all ones, random low bits in the root base and random reserved bits in the entries would expose an index taken from the wrong bit field or a frame number that included reserved bits. Random stalls on the memory and response handshakes show whether the walker holds its outputs and its busy state until each handshake completes.

// File: rtl/pgw_pkg.sv
`timescale 1ns/1ps
package pgw_pkg;
  localparam int PTE_PRESENT_BIT = 0;
  localparam int PTE_DIRTY_BIT   = 1;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_ROOT_REQ  = 3'd1,
    ST_ROOT_WAIT = 3'd2,
    ST_LEAF_REQ  = 3'd3,
    ST_LEAF_WAIT = 3'd4,
    ST_WB_REQ    = 3'd5,
    ST_WB_WAIT   = 3'd6,
    ST_RESP      = 3'd7
  } walk_state_e;

  typedef enum logic {
    LVL_ROOT = 1'b0,
    LVL_LEAF = 1'b1
  } walk_level_e;
endpackage

// File: rtl/pgw_rst_sync.sv
`timescale 1ns/1ps
// Asserts reset at once and releases it after STAGES clock edges.
module pgw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/pgw_entry_addr.sv
`timescale 1ns/1ps
// Word address of a table entry: table base frame followed by the index.
module pgw_entry_addr #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  localparam int FRAME_W  = ADDR_W - OFF_W,
  localparam int IDX_W    = OFF_W - 2,
  localparam int ROOT_W   = ADDR_W - OFF_W - IDX_W,
  localparam int WADDR_W  = ADDR_W - 2
) (
  input  logic [FRAME_W-1:0] base_frame,
  input  logic [ADDR_W-1:0]  vaddr,
  input  logic               sel_leaf,
  output logic [WADDR_W-1:0] waddr
);
  logic [WADDR_W-1:0] base_word;
  logic [WADDR_W-1:0] root_idx;
  logic [WADDR_W-1:0] leaf_idx;

  assign base_word = {base_frame, {IDX_W{1'b0}}};
  assign leaf_idx  = WADDR_W'(vaddr[OFF_W +: IDX_W]);

  generate
    if (ROOT_W == IDX_W) begin : g_root_fit
      assign root_idx = WADDR_W'(vaddr[ADDR_W-1 -: ROOT_W]);
    end else if (ROOT_W < IDX_W) begin : g_root_narrow
      assign root_idx = WADDR_W'({{(IDX_W-ROOT_W){1'b0}}, vaddr[ADDR_W-1 -: ROOT_W]});
    end else begin : g_root_wide
      assign root_idx = WADDR_W'(vaddr[ADDR_W-1 -: ROOT_W]);
    end
  endgenerate

  always_comb begin
    if (sel_leaf) waddr = base_word + leaf_idx;
    else          waddr = base_word + root_idx;
  end
endmodule

// File: rtl/pgw_pte_fields.sv
`timescale 1ns/1ps
// Splits a table entry into the fields the walker acts on.
module pgw_pte_fields
  import pgw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  localparam int FRAME_W = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0]  pte,
  output logic               present,
  output logic               dirty,
  output logic [FRAME_W-1:0] frame,
  output logic [ADDR_W-1:0]  pte_marked
);
  logic unused_rsvd;

  assign present     = pte[PTE_PRESENT_BIT];
  assign dirty       = pte[PTE_DIRTY_BIT];
  assign frame       = pte[ADDR_W-1:OFF_W];
  assign unused_rsvd = ^pte[OFF_W-1:PTE_DIRTY_BIT+1];

  always_comb begin
    pte_marked                = pte;
    pte_marked[PTE_DIRTY_BIT] = 1'b1;
  end
endmodule

// File: rtl/pgw_walk_ctrl.sv
`timescale 1ns/1ps
// Walk sequencer: state machine, captured request, and walk results.
module pgw_walk_ctrl
  import pgw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  localparam int FRAME_W = ADDR_W - OFF_W,
  localparam int WADDR_W = ADDR_W - 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_vaddr,
  input  logic               req_store,
  input  logic [ADDR_W-1:0]  req_root_base,
  output logic               resp_valid,
  input  logic               resp_ready,
  output logic               resp_fault,
  output logic               resp_fault_leaf,
  output logic [ADDR_W-1:0]  resp_paddr,
  output logic [ADDR_W-1:0]  resp_pte,
  output logic [FRAME_W-1:0] resp_vpn,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_we,
  output logic [WADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0]  mem_wdata,
  input  logic               mem_rsp_valid,
  input  logic [ADDR_W-1:0]  mem_rdata,
  output logic [FRAME_W-1:0] ea_base,
  output logic [ADDR_W-1:0]  ea_vaddr,
  output logic               ea_sel_leaf,
  input  logic [WADDR_W-1:0] ea_waddr,
  input  logic               rd_present,
  input  logic               rd_dirty,
  input  logic [FRAME_W-1:0] rd_frame,
  input  logic [ADDR_W-1:0]  rd_marked
);
  walk_state_e        state_q, state_d;
  logic [ADDR_W-1:0]  va_q;
  logic               store_q;
  logic [FRAME_W-1:0] root_q;
  logic [FRAME_W-1:0] tab_q, tab_d;
  logic               tab_en;
  logic [ADDR_W-1:0]  pte_q, pte_d;
  logic               pte_en;
  logic               fault_q, fault_d;
  walk_level_e        lvl_q, lvl_d;
  logic               res_en;
  logic               take_req;
  logic               unused_base;

  assign take_req    = (state_q == ST_IDLE) && req_valid;
  assign unused_base = ^req_root_base[OFF_W-1:0];

  // Next-state and result selection.
  always_comb begin
    state_d = state_q;
    tab_d   = tab_q;
    tab_en  = 1'b0;
    pte_d   = pte_q;
    pte_en  = 1'b0;
    fault_d = fault_q;
    lvl_d   = lvl_q;
    res_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = ST_ROOT_REQ;
          res_en  = 1'b1;
          fault_d = 1'b0;
          lvl_d   = LVL_ROOT;
        end
      end
      ST_ROOT_REQ: begin
        if (mem_req_ready) state_d = ST_ROOT_WAIT;
      end
      ST_ROOT_WAIT: begin
        if (mem_rsp_valid) begin
          pte_en = 1'b1;
          pte_d  = mem_rdata;
          if (!rd_present) begin
            res_en  = 1'b1;
            fault_d = 1'b1;
            lvl_d   = LVL_ROOT;
            state_d = ST_RESP;
          end else begin
            tab_en  = 1'b1;
            tab_d   = rd_frame;
            state_d = ST_LEAF_REQ;
          end
        end
      end
      ST_LEAF_REQ: begin
        if (mem_req_ready) state_d = ST_LEAF_WAIT;
      end
      ST_LEAF_WAIT: begin
        if (mem_rsp_valid) begin
          pte_en = 1'b1;
          res_en = 1'b1;
          lvl_d  = LVL_LEAF;
          if (!rd_present) begin
            pte_d   = mem_rdata;
            fault_d = 1'b1;
            state_d = ST_RESP;
          end else if (store_q && !rd_dirty) begin
            pte_d   = rd_marked;
            fault_d = 1'b0;
            state_d = ST_WB_REQ;
          end else begin
            pte_d   = mem_rdata;
            fault_d = 1'b0;
            state_d = ST_RESP;
          end
        end
      end
      ST_WB_REQ: begin
        if (mem_req_ready) state_d = ST_WB_WAIT;
      end
      ST_WB_WAIT: begin
        if (mem_rsp_valid) state_d = ST_RESP;
      end
      ST_RESP: begin
        if (resp_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // State register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // Request capture, enabled on acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q    <= '0;
      store_q <= 1'b0;
      root_q  <= '0;
    end else if (take_req) begin
      va_q    <= req_vaddr;
      store_q <= req_store;
      root_q  <= req_root_base[ADDR_W-1:OFF_W];
    end
  end

  // Second-level table base.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tab_q <= '0;
    else if (tab_en) tab_q <= tab_d;
  end

  // Entry register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pte_q <= '0;
    else if (pte_en) pte_q <= pte_d;
  end

  // Fault outcome.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      lvl_q   <= LVL_ROOT;
    end else if (res_en) begin
      fault_q <= fault_d;
      lvl_q   <= lvl_d;
    end
  end

  // Entry address source.
  assign ea_base     = (state_q == ST_ROOT_REQ) ? root_q : tab_q;
  assign ea_vaddr    = va_q;
  assign ea_sel_leaf = (state_q != ST_ROOT_REQ);

  // Memory side.
  assign mem_req_valid = (state_q == ST_ROOT_REQ) || (state_q == ST_LEAF_REQ) ||
                         (state_q == ST_WB_REQ);
  assign mem_we        = (state_q == ST_WB_REQ);
  assign mem_addr      = ea_waddr;
  assign mem_wdata     = pte_q;

  // Request / response side.
  assign req_ready       = (state_q == ST_IDLE);
  assign resp_valid      = (state_q == ST_RESP);
  assign resp_fault      = fault_q;
  assign resp_fault_leaf = (lvl_q == LVL_LEAF);
  assign resp_pte        = pte_q;
  assign resp_vpn        = va_q[ADDR_W-1:OFF_W];
  assign resp_paddr      = fault_q ? '0 : {pte_q[ADDR_W-1:OFF_W], va_q[OFF_W-1:0]};
endmodule

// File: rtl/pgw_walker.sv
`timescale 1ns/1ps
// Two-level page table walker, top level.
module pgw_walker
  import pgw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  localparam int FRAME_W = ADDR_W - OFF_W,
  localparam int WADDR_W = ADDR_W - 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_vaddr,
  input  logic               req_store,
  input  logic [ADDR_W-1:0]  req_root_base,
  output logic               resp_valid,
  input  logic               resp_ready,
  output logic               resp_fault,
  output logic               resp_fault_leaf,
  output logic [ADDR_W-1:0]  resp_paddr,
  output logic [ADDR_W-1:0]  resp_pte,
  output logic [FRAME_W-1:0] resp_vpn,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_we,
  output logic [WADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0]  mem_wdata,
  input  logic               mem_rsp_valid,
  input  logic [ADDR_W-1:0]  mem_rdata
);
  logic               rst_n_sync;
  logic [FRAME_W-1:0] ea_base;
  logic [ADDR_W-1:0]  ea_vaddr;
  logic               ea_sel_leaf;
  logic [WADDR_W-1:0] ea_waddr;
  logic               rd_present;
  logic               rd_dirty;
  logic [FRAME_W-1:0] rd_frame;
  logic [ADDR_W-1:0]  rd_marked;

  pgw_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  pgw_entry_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
    .base_frame (ea_base),
    .vaddr      (ea_vaddr),
    .sel_leaf   (ea_sel_leaf),
    .waddr      (ea_waddr)
  );

  pgw_pte_fields #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dec (
    .pte        (mem_rdata),
    .present    (rd_present),
    .dirty      (rd_dirty),
    .frame      (rd_frame),
    .pte_marked (rd_marked)
  );

  pgw_walk_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n_sync),
    .req_valid       (req_valid),
    .req_ready       (req_ready),
    .req_vaddr       (req_vaddr),
    .req_store       (req_store),
    .req_root_base   (req_root_base),
    .resp_valid      (resp_valid),
    .resp_ready      (resp_ready),
    .resp_fault      (resp_fault),
    .resp_fault_leaf (resp_fault_leaf),
    .resp_paddr      (resp_paddr),
    .resp_pte        (resp_pte),
    .resp_vpn        (resp_vpn),
    .mem_req_valid   (mem_req_valid),
    .mem_req_ready   (mem_req_ready),
    .mem_we          (mem_we),
    .mem_addr        (mem_addr),
    .mem_wdata       (mem_wdata),
    .mem_rsp_valid   (mem_rsp_valid),
    .mem_rdata       (mem_rdata),
    .ea_base         (ea_base),
    .ea_vaddr        (ea_vaddr),
    .ea_sel_leaf     (ea_sel_leaf),
    .ea_waddr        (ea_waddr),
    .rd_present      (rd_present),
    .rd_dirty        (rd_dirty),
    .rd_frame        (rd_frame),
    .rd_marked       (rd_marked)
  );
endmodule

// File: rtl/pgw_walker_checker.sv
`timescale 1ns/1ps
module pgw_walker_checker #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  localparam int FRAME_W = ADDR_W - OFF_W,
  localparam int WADDR_W = ADDR_W - 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [ADDR_W-1:0]  req_vaddr,
  input logic               resp_valid,
  input logic               resp_ready,
  input logic               resp_fault,
  input logic               resp_fault_leaf,
  input logic [ADDR_W-1:0]  resp_paddr,
  input logic [ADDR_W-1:0]  resp_pte,
  input logic [FRAME_W-1:0] resp_vpn,
  input logic               mem_req_valid,
  input logic               mem_req_ready,
  input logic               mem_we,
  input logic [WADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0]  mem_wdata
);
  logic [ADDR_W-1:0] va_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      va_seen <= '0;
    else if (req_valid && req_ready) va_seen <= req_vaddr;
  end

  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !req_ready);

  assert_resp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_fault) &&
      $stable(resp_fault_leaf) && $stable(resp_paddr) && $stable(resp_pte) &&
      $stable(resp_vpn)));

  assert_memreq_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr) &&
      $stable(mem_we) && $stable(mem_wdata)));

  assert_fault_no_paddr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault) |-> (resp_paddr == '0));

  assert_wb_marks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_we) |-> (mem_wdata[1] && mem_wdata[0]));

  assert_offset_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_fault) |-> ((resp_paddr[OFF_W-1:0] == va_seen[OFF_W-1:0]) &&
      (resp_paddr[ADDR_W-1:OFF_W] == resp_pte[ADDR_W-1:OFF_W])));

  assert_vpn_R5: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_vpn == va_seen[ADDR_W-1:OFF_W]));
endmodule

bind pgw_walker pgw_walker_checker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid       (req_valid),
  .req_ready       (req_ready),
  .req_vaddr       (req_vaddr),
  .resp_valid      (resp_valid),
  .resp_ready      (resp_ready),
  .resp_fault      (resp_fault),
  .resp_fault_leaf (resp_fault_leaf),
  .resp_paddr      (resp_paddr),
  .resp_pte        (resp_pte),
  .resp_vpn        (resp_vpn),
  .mem_req_valid   (mem_req_valid),
  .mem_req_ready   (mem_req_ready),
  .mem_we          (mem_we),
  .mem_addr        (mem_addr),
  .mem_wdata       (mem_wdata)
);

// File: tb/sim_pgw_walker.sv
`timescale 1ns/1ps
module sim_pgw_walker;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic        req_store;
  logic [31:0] req_root_base;
  logic        resp_valid;
  logic        resp_ready;
  logic        resp_fault;
  logic        resp_fault_leaf;
  logic [31:0] resp_paddr;
  logic [31:0] resp_pte;
  logic [19:0] resp_vpn;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic        mem_we;
  logic [29:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_rsp_valid;
  logic [31:0] mem_rdata;

  int checks = 0;
  int errors = 0;

  pgw_walker u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_store(req_store), .req_root_base(req_root_base),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_fault(resp_fault),
    .resp_fault_leaf(resp_fault_leaf), .resp_paddr(resp_paddr), .resp_pte(resp_pte),
    .resp_vpn(resp_vpn),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Sparse table memory, written only by the stimulus tasks.
  logic [31:0] mem [logic [29:0]];

  function automatic logic [31:0] rd_word(input logic [29:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  // Memory responder and access log.
  logic        pend;
  int          dly;
  logic [29:0] p_addr;
  logic        p_we;
  int          log_n;
  logic [29:0] log_addr [4096];
  logic        log_we   [4096];
  logic [31:0] log_wd   [4096];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req_ready <= 1'b0;
      mem_rsp_valid <= 1'b0;
      mem_rdata     <= 32'h0;
      pend          <= 1'b0;
      dly           <= 0;
      p_addr        <= '0;
      p_we          <= 1'b0;
      log_n         <= 0;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        pend          <= 1'b1;
        dly           <= int'($urandom % 4);
        p_addr        <= mem_addr;
        p_we          <= mem_we;
        mem_req_ready <= 1'b0;
        if (log_n < 4096) begin
          log_addr[log_n] <= mem_addr;
          log_we[log_n]   <= mem_we;
          log_wd[log_n]   <= mem_wdata;
        end
        log_n <= log_n + 1;
      end else if (pend) begin
        mem_req_ready <= 1'b0;
        if (dly == 0) begin
          mem_rsp_valid <= 1'b1;
          mem_rdata     <= p_we ? 32'h0 : rd_word(p_addr);
          pend          <= 1'b0;
        end else begin
          dly <= dly - 1;
        end
      end else begin
        mem_req_ready <= ($urandom % 2) == 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One translation, checked against values computed from the table contents.
  task automatic walk(input logic [31:0] va, input logic store, input logic [31:0] base);
    logic [29:0] rwa, lwa;
    logic [31:0] re, le, e_pte, e_pa;
    logic        e_fault, e_leaf, e_wb;
    int          e_cnt, start, n;
    bit          rdy, got, last_rdy, done, busy_bad, stab_bad;
    logic [31:0] c_pa, c_pte;
    logic [19:0] c_vpn;
    logic        c_f, c_l;

    rwa = {base[31:12], va[31:22]};
    re  = rd_word(rwa);
    lwa = {re[31:12], va[21:12]};
    le  = rd_word(lwa);
    e_wb = 1'b0;
    if (!re[0]) begin
      e_fault = 1; e_leaf = 0; e_pte = re; e_pa = 0; e_cnt = 1;
    end else if (!le[0]) begin
      e_fault = 1; e_leaf = 1; e_pte = le; e_pa = 0; e_cnt = 2;
    end else begin
      e_fault = 0; e_leaf = 1;
      e_wb  = store && !le[1];
      e_pte = e_wb ? (le | 32'h2) : le;
      e_pa  = {le[31:12], va[11:0]};
      e_cnt = e_wb ? 3 : 2;
    end

    @(negedge clk);
    if ($urandom % 4 == 0) @(negedge clk);
    start = log_n;
    req_valid = 1'b1; req_vaddr = va; req_store = store; req_root_base = base;
    rdy = 1'b0;
    while (!rdy) begin
      rdy = req_ready;
      @(posedge clk);
    end
    got = 0; last_rdy = 0; done = 0; busy_bad = 0; stab_bad = 0;
    c_pa = 0; c_pte = 0; c_vpn = 0; c_f = 0; c_l = 0;
    while (!done) begin
      @(negedge clk);
      req_valid = 1'b0;
      req_vaddr = $urandom; req_store = $urandom; req_root_base = $urandom;
      if (got && last_rdy) begin
        done = 1;
        resp_ready = 1'b0;
      end else begin
        if (req_ready) busy_bad = 1;
        if (resp_valid) begin
          if (!got) begin
            c_pa = resp_paddr; c_pte = resp_pte; c_vpn = resp_vpn;
            c_f = resp_fault; c_l = resp_fault_leaf;
          end else if (c_pa != resp_paddr || c_pte != resp_pte || c_vpn != resp_vpn ||
                       c_f != resp_fault || c_l != resp_fault_leaf) begin
            stab_bad = 1;
          end
          got = 1;
          last_rdy = ($urandom % 3) != 0;
          resp_ready = last_rdy;
        end
      end
    end
    n = log_n - start;

    chk(!busy_bad, "R9", "req_ready high while busy", 32'(busy_bad), 32'h0);
    chk(!stab_bad, "R9", "response changed under stall", 32'(stab_bad), 32'h0);
    chk(req_ready == 1'b1, "R9", "req_ready after handshake", 32'(req_ready), 32'h1);
    chk(c_f == e_fault, e_fault ? (e_leaf ? "R6" : "R5") : "R4", "fault", 32'(c_f), 32'(e_fault));
    if (e_fault) chk(c_l == e_leaf, e_leaf ? "R6" : "R5", "fault level", 32'(c_l), 32'(e_leaf));
    chk(c_pa == e_pa, e_fault ? "R5" : "R4", "paddr", c_pa, e_pa);
    chk(c_pte == e_pte, "R10", "entry returned", c_pte, e_pte);
    chk(c_vpn == va[31:12], "R4", "vpn", 32'(c_vpn), 32'(va[31:12]));
    chk(n == e_cnt, e_wb ? "R7" : "R8", "access count", 32'(n), 32'(e_cnt));
    if (n >= 1)
      chk(log_addr[start] == rwa && !log_we[start], "R2", "root read addr",
          32'(log_addr[start]), 32'(rwa));
    if (n >= 2 && e_cnt >= 2)
      chk(log_addr[start+1] == lwa && !log_we[start+1], "R3", "leaf read addr",
          32'(log_addr[start+1]), 32'(lwa));
    if (e_wb && n >= 3) begin
      chk(log_we[start+2] && log_addr[start+2] == lwa, "R7", "write-back addr",
          32'(log_addr[start+2]), 32'(lwa));
      chk(log_wd[start+2] == (le | 32'h2), "R7", "write-back data",
          log_wd[start+2], le | 32'h2);
    end
    if (!e_wb && n >= 2)
      chk(!log_we[start+1], "R8", "no write", 32'(log_we[start+1]), 32'h0);
  endtask

  // Places entries for a walk. kind: 0 root absent, 1 leaf absent, else present.
  // Reserved bits 11:2 are filled at random (R10).
  task automatic place(input logic [31:0] va, input logic [31:0] base, input int kind,
                       input logic dirty);
    logic [31:0] re, le;
    re = $urandom;
    le = $urandom;
    re[0] = (kind != 0);
    le[0] = (kind >= 2);
    le[1] = dirty;
    mem[{base[31:12], va[31:22]}] = re;
    mem[{re[31:12], va[21:12]}]   = le;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    req_valid = 0; req_vaddr = 0; req_store = 0; req_root_base = 0; resp_ready = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready in reset", 32'(req_ready), 32'h1);
    chk(resp_valid == 1'b0, "R1", "resp_valid in reset", 32'(resp_valid), 32'h0);
    chk(mem_req_valid == 1'b0, "R1", "mem_req_valid in reset", 32'(mem_req_valid), 32'h0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // Directed corners.
    place(32'h0, 32'h0000_1000, 2, 1'b0);
    walk(32'h0, 1'b0, 32'h0000_1000);                // R8 load, clean page
    place(32'hFFFF_FFFF, 32'hFFFF_F000, 2, 1'b0);
    walk(32'hFFFF_FFFF, 1'b1, 32'hFFFF_F000);        // R7 store, clean page
    place(32'h1234_5678, 32'h0040_0000, 2, 1'b1);
    walk(32'h1234_5678, 1'b1, 32'h0040_0000);        // R8 store, already modified
    place(32'h8000_0ABC, 32'h0002_0000, 0, 1'b0);
    walk(32'h8000_0ABC, 1'b0, 32'h0002_0000);        // R5 root fault
    place(32'h0040_3FFF, 32'h0003_0000, 1, 1'b0);
    walk(32'h0040_3FFF, 1'b1, 32'h0003_0000);        // R6 leaf fault on store
    place(32'h7FC0_1001, 32'h0005_0000, 2, 1'b0);
    walk(32'h7FC0_1001, 1'b0, 32'h0005_0FFF);        // R10/R2 base low bits ignored

    for (int i = 0; i < 300; i++) begin
      logic [31:0] va, base;
      int kind;
      va   = $urandom;
      base = $urandom;
      kind = int'($urandom % 5);
      place(va, base, kind, 1'($urandom));
      walk(va, 1'($urandom), base);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule